// File: doc/BRIEF.md
# Cycle-Prescaled Up-Counting Interrupt Timer

This block is an interrupt timer paced by processor cycles. A qualifier input marks the clocks that carry one processor cycle. While the timer runs, a prescaler counts these cycles, and every 114th one advances an 8-bit counter by one. When a step finds the counter at 0xFF, the counter reloads from a reload register and a level interrupt request is raised. Software sets up the reload value and a two-bit control field through single-cycle bus writes.

The control field holds a run bit and a keep-running bit. Setting the run bit by a write restarts the timer from the reload value with an empty prescaler. On each overflow the run bit takes the value of the keep-running bit. With that bit set the timer is periodic; with it clear the timer fires once. Any write to the control address acknowledges a pending request. Bus writes are always accepted in the cycle they are presented, so the write port has no back-pressure and no valid/ready pair. The counter value is also driven out, so software or a neighbouring block can see the timer's progress.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write to address 0xF008 replaces bits [3:0] of the 8-bit reload register with wr_data[3:0]. Bits [7:4] keep their value, which is zero from reset.
- R2: Writes to any address other than 0xF008 and 0xF00C, including 0xF000 and 0xF004, change neither tmr_count nor irq, and have no effect on later timing.
- R3: A write to 0xF00C stores wr_data[1] as the run bit and wr_data[0] as the keep-running bit. When wr_data[1] is 1, tmr_count takes the reload value on the next clock and the prescaler restarts from zero.
- R4: Any write to 0xF00C clears irq on the next clock.
- R5: The prescaler counts clocks with cpu_tick high, but only while the run bit is 1. On every 114th such clock it performs one counter step. While the run bit is 0, tmr_count holds its value.
- R6: On a counter step, tmr_count goes to the reload value and irq goes high if tmr_count was 0xFF. On any other step, tmr_count increments by one. After the timer is started with reload value L, irq rises exactly (256-L)*114 ticks later.
- R7: On an overflow step the run bit takes the value of the keep-running bit. With the keep-running bit 1 the counter keeps stepping after the overflow. With it 0 the counter stays at the reload value.
- R8: After reset, irq is 0, tmr_count is 0x00, the reload register and the prescaler are zero, and both control bits are 0.
- R9: irq is a level. Once it is set, it stays high until a write to 0xF00C, even if more overflows occur.
- R10: When a write to 0xF00C and a counter step fall in the same clock, the write wins. The step is dropped, even when it would have been an overflow, and no irq is raised by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per clock it is high |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| cpu_tick | input | 1 | High on clocks that carry one processor cycle |
| irq | output | 1 | Level interrupt request |
| tmr_count | output | 8 | Current counter value |

## Verification
Two things can fall in the same clock: a control write and the counter step that the prescaler produces on its 114th tick. The worst case is a step that would overflow the counter. The bench follows its own behavioural model until the counter is at 0xFF and the prescaler is one tick from a step. It then presents a control write together with a tick in that exact clock. The check passes only if no irq appears, the counter holds the reload value and the next overflow comes a full period later. The model is compared against irq and tmr_count on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control field: run enables the prescaler, keep decides run after overflow
  typedef struct packed {
    logic run;
    logic keep;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_RUN_BIT  = 1;
  localparam int unsigned CTRL_KEEP_BIT = 0;

  function automatic tmr_ctrl_t ctrl_from_data(input logic [1:0] d);
    tmr_ctrl_t c;
    c.run  = d[CTRL_RUN_BIT];
    c.keep = d[CTRL_KEEP_BIT];
    return c;
  endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_RELOAD = 16'hF008,
  parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'hF00C
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              reload_we,
  output logic              ctrl_we
);
  always_comb begin
    reload_we = wr_en && (wr_addr == ADDR_RELOAD);
    ctrl_we   = wr_en && (wr_addr == ADDR_CTRL);
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRESCALE = 114,
  localparam int unsigned PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,   // clear to zero
  input  logic             freeze,    // control write without restart: hold
  input  logic             run,
  input  logic             tick,
  output logic             step,
  output logic [PRE_W-1:0] pre_q
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  logic advance;

  always_comb begin
    advance = run && tick && !restart && !freeze;
    step    = advance && (pre_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (advance) begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_comb wrap = step && !load && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload_val;
    end else if (step) begin
      cnt_q <= (cnt_q == TOP) ? reload_val : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned PRESCALE = 114,
  parameter logic [ADDR_W-1:0] ADDR_RELOAD = 16'hF008,
  parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'hF00C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_tick,
  output logic              irq,
  output logic [CNT_W-1:0]  tmr_count
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             reload_we, ctrl_we, restart, freeze;
  logic             step, wrap;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] reload_q;
  tmr_ctrl_t        ctrl_q;
  tmr_ctrl_t        ctrl_wr;

  tmr_bus_decode #(
    .ADDR_W(ADDR_W), .ADDR_RELOAD(ADDR_RELOAD), .ADDR_CTRL(ADDR_CTRL)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .reload_we(reload_we), .ctrl_we(ctrl_we)
  );

  always_comb begin
    ctrl_wr = ctrl_from_data(wr_data[1:0]);
    restart = ctrl_we && ctrl_wr.run;
    freeze  = ctrl_we && !ctrl_wr.run;
  end

  tmr_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .freeze(freeze),
    .run(ctrl_q.run), .tick(cpu_tick), .step(step), .pre_q(pre_q)
  );

  tmr_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(restart), .step(step),
    .reload_val(reload_q), .wrap(wrap), .cnt_q(tmr_count)
  );

  // Reload register: only the low nibble is writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_we) begin
      reload_q[NIB_W-1:0] <= wr_data[NIB_W-1:0];
    end
  end

  // Control bits; a write wins over the overflow update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wr;
    end else if (wrap) begin
      ctrl_q.run <= ctrl_q.keep;
    end
  end

  // Level request, acknowledged by any control write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (ctrl_we) begin
      irq <= 1'b0;
    end else if (wrap) begin
      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRE_W    = 7,
  parameter int unsigned PRESCALE = 114
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             restart,
  input logic             step,
  input logic             irq,
  input logic [CNT_W-1:0] tmr_count,
  input logic [CNT_W-1:0] reload_q,
  input logic [PRE_W-1:0] pre_q,
  input logic             run,
  input logic             keep
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !irq);

  a_r3_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tmr_count == $past(reload_q)) && (pre_q == '0));

  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < PRE_W'(PRESCALE));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_we) |=> $stable(tmr_count));

  a_r6_fire_from_top: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tmr_count) == TOP && tmr_count == $past(reload_q));

  a_r7_run_follows_keep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> run == keep);

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_we) |=> irq);

  a_r10_write_drops_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && step) |-> 1'b0);
endmodule

bind cyc_irq_timer tmr_checker #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .PRESCALE(PRESCALE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .restart(restart),
  .step(step), .irq(irq), .tmr_count(tmr_count), .reload_q(reload_q),
  .pre_q(pre_q), .run(ctrl_q.run), .keep(ctrl_q.keep)
);

// File: tb/cyc_irq_timer_tb.sv
`timescale 1ns/1ps
module cyc_irq_timer_tb;
  localparam int PRESCALE = 114;
  localparam logic [15:0] A_RELOAD = 16'hF008;
  localparam logic [15:0] A_CTRL   = 16'hF00C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        irq;
  logic [7:0]  tmr_count;

  always #2.5 clk = ~clk;

  cyc_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq), .tmr_count(tmr_count)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  bit    cmp_on  = 0;
  string phase   = "R8";

  // Behavioural reference model
  int m_pre, m_cnt, m_reload, m_irq, m_run, m_keep;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_reload = 0; m_irq = 0; m_run = 0; m_keep = 0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        m_keep = wr_data[0];
        m_run  = wr_data[1];
        m_irq  = 0;
        if (wr_data[1]) begin m_cnt = m_reload; m_pre = 0; end
      end else if (m_run != 0 && cpu_tick) begin
        m_pre++;
        if (m_pre == PRESCALE) begin
          m_pre = 0;
          if (m_cnt == 255) begin m_cnt = m_reload; m_irq = 1; m_run = m_keep; end
          else m_cnt++;
        end
      end
      if (wr_en && wr_addr == A_RELOAD) m_reload = (m_reload & 'hF0) | wr_data[3:0];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare DUT to model on every clock
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(irq == m_irq[0], {phase, " irq"}, irq, m_irq);
      check(tmr_count == m_cnt[7:0], {phase, " count"}, tmr_count, m_cnt);
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  bit gated = 0;

  function automatic bit next_tick();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return gated ? (lfsr[1:0] != 2'b00) : 1'b1;
  endfunction

  task automatic drive(input bit we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; cpu_tick = next_tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 16'h0000, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k;
    logic [7:0] held;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(irq == 1'b0, "R8 irq", irq, 0);
    check(tmr_count == 8'h00, "R8 count", tmr_count, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(300);
    check(tmr_count == 8'h00 && !irq, "R8 idle after reset", tmr_count, 0);

    // R1: only low nibble of reload is taken (0x3F -> 0x0F)
    phase = "R1";
    drive(1, A_RELOAD, 8'h3F);
    // R2: ignored addresses
    phase = "R2";
    drive(1, 16'hF000, 8'hFF);
    drive(1, 16'hF004, 8'hFF);
    drive(1, 16'h1234, 8'h03);
    idle(3);
    check(tmr_count == 8'h00 && !irq, "R2 ignored writes", tmr_count, 0);

    // R3/R6: periodic start, exact fire time (256-15)*114
    phase = "R6";
    drive(1, A_CTRL, 8'h03);
    k = 0;
    for (int i = 1; i <= 28000; i++) begin
      drive(0, 16'h0000, 8'h00);
      if (i == 1) check(tmr_count == 8'h0F, "R3 load reload on start", tmr_count, 8'h0F);
      if (irq) begin k = i; break; end
    end
    check(k == 241 * PRESCALE + 1, "R6 fire time", k, 241 * PRESCALE + 1);
    check(tmr_count == 8'h0F, "R6 reload on overflow", tmr_count, 8'h0F);

    // R7/R9: keeps running, irq held
    phase = "R9";
    idle(200);
    check(irq == 1'b1, "R9 irq level held", irq, 1);
    check(tmr_count == 8'h10, "R7 periodic keeps stepping", tmr_count, 8'h10);

    // R4: acknowledge and restart
    phase = "R4";
    drive(1, A_CTRL, 8'h03);
    drive(0, 16'h0000, 8'h00);
    check(irq == 1'b0, "R4 ack clears irq", irq, 0);

    // R10: control write on the overflow step
    phase = "R10";
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (m_cnt == 255 && m_pre == PRESCALE - 1) begin
        wr_en = 1; wr_addr = A_CTRL; wr_data = 8'h03; cpu_tick = 1'b1;
        break;
      end
      wr_en = 0; cpu_tick = next_tick();
    end
    drive(0, 16'h0000, 8'h00);
    check(irq == 1'b0, "R10 no irq from dropped step", irq, 0);
    check(tmr_count == 8'h0F, "R10 write wins, reload", tmr_count, 8'h0F);

    // R5: stop with run=0, count holds
    phase = "R5";
    idle(5 * PRESCALE + 7);
    drive(1, A_CTRL, 8'h01);
    drive(0, 16'h0000, 8'h00);
    held = tmr_count;
    idle(3 * PRESCALE);
    check(tmr_count == held, "R5 stopped count holds", tmr_count, held);
    check(held == 8'h14, "R5 step count while running", held, 8'h14);

    // R1: new reload 0xAC -> 0x0C, one-shot with gated ticks
    phase = "R7";
    drive(1, A_RELOAD, 8'hAC);
    gated = 1;
    drive(1, A_CTRL, 8'h02);
    drive(0, 16'h0000, 8'h00);
    check(tmr_count == 8'h0C, "R1 low nibble written", tmr_count, 8'h0C);
    for (int i = 0; i < 40000; i++) begin
      drive(0, 16'h0000, 8'h00);
      if (irq) break;
    end
    check(irq == 1'b1, "R6 one-shot fired", irq, 1);
    idle(4 * PRESCALE);
    check(tmr_count == 8'h0C, "R7 one-shot stops at reload", tmr_count, 8'h0C);
    check(irq == 1'b1, "R9 irq still held", irq, 1);

    phase = "R4";
    drive(1, A_CTRL, 8'h00);
    drive(0, 16'h0000, 8'h00);
    check(irq == 1'b0, "R4 ack with zero data", irq, 0);
    idle(10);
    finish_run();
  end
endmodule